// File: doc/BRIEF.md
# Keyed Flash Command Controller

This block sits between a register port and an abstract flash-array port. Software writes a 32-bit command word that carries a protection key, an opcode and a page number. The controller rejects words with a bad key or an undefined opcode, and it rejects words that arrive while another command is in flight. It refuses page writes and erases that touch a locked region or the protected boot pages. Accepted commands either finish locally in one cycle or are handed to the flash array as a start pulse with opcode and page, after which the controller waits for a done pulse.

While a command runs on the array, memory-read requests are held off. A ready flag, sticky error flags and a completion interrupt report progress. Region locks live in a 16-bit bitmap that is changed by dedicated lock and unlock commands.

Register map, selected by `reg_addr`:
- 0 is control; bit 0 enables the interrupt.
- 1 is the command register, which can only be written.
- 2 is status: bit 0 ready, bit 1 programming error, bit 2 lock error.
- 3 is the lock bitmap, which can only be read.

Reads return data combinationally. Only a cycle with `reg_rd` high at address 2 counts as a status read.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: The command word holds key 0xA5 in bits 31:24, the opcode in bits 5:0 and the page in bits 23:8. The defined opcodes are 0 no-op, 1 write page, 2 erase page, 3 clear page buffer, 4 lock, 5 unlock, 6 erase all, 12 quick read and 15 quick user read. A word with any other key or opcode never starts the array and sets the programming-error flag (status bit 1).
- R2: A command write made while a command is pending or executing is ignored: there is no extra start and ready stays low. It also sets the programming-error flag.
- R3: Write page or erase page aimed at a page below 16, or at a page whose region bits 15:12 index a set lock bit, is refused: there is no array start and lock error (status bit 2) is set. Erase all is refused the same way whenever any lock bit is set.
- R4: Both error flags are sticky and are cleared by a status read. An error event in the same cycle wins over the clear.
- R5: Ready (status bit 0) is 1 after reset. It reads 0 from the cycle after an accepted command write and returns to 1 the cycle after completion. Rejected writes leave it unchanged.
- R6: `irq` equals the enable bit ANDed with a pending flag. The pending flag is set when any command other than 12 or 15 completes, and is cleared by a status read or by the next accepted command.
- R7: Array commands (1, 2, 6, 12, 15) assert `fl_start`, with the opcode and page, in the first cycle after acceptance in which `mem_rd_req` is low. Local and refused commands complete one cycle after acceptance.
- R8: `mem_rd_ready` is low from the cycle after `fl_start` until the `fl_done` cycle, and high otherwise.
- R9: `pbuf_clear` pulses in the cycle after an accepted opcode 3 and never for a page write.
- R10: Lock sets, and unlock clears, the lock-bitmap bit indexed by page bits 15:12. The change is visible the cycle after completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| reg_wr | input | 1 | register write strobe |
| reg_rd | input | 1 | register read strobe (clears errors at address 2) |
| reg_addr | input | 2 | register select |
| reg_wdata | input | 32 | write data |
| reg_rdata | output | 32 | read data for `reg_addr` |
| irq | output | 1 | completion interrupt |
| mem_rd_req | input | 1 | memory read request; low marks an idle bus cycle |
| mem_rd_ready | output | 1 | read may proceed; low stalls the read |
| fl_start | output | 1 | start pulse to the flash array |
| fl_op | output | 6 | opcode issued with the start |
| fl_page | output | 16 | page issued with the start |
| fl_done | input | 1 | completion pulse from the flash array |
| pbuf_clear | output | 1 | page-buffer clear pulse |

## Verification
The command write is captured at one clock edge. The error flags and the drop of ready are due right after that edge. A local command's completion (ready, irq, lock bitmap) is due one edge later, and `pbuf_clear` is visible between those two edges. For array commands, `fl_start` appears in the first low-`mem_rd_req` cycle and the stall holds from the next edge until the edge that sees `fl_done`. The bench drives on falling edges and samples on the falling edge that follows each due edge, stepping its reference model cycle by cycle with the same counts.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
  localparam logic [7:0] CMD_KEY = 8'hA5;

  localparam logic [5:0] OP_NOP  = 6'd0;
  localparam logic [5:0] OP_WRP  = 6'd1;
  localparam logic [5:0] OP_ERP  = 6'd2;
  localparam logic [5:0] OP_CPB  = 6'd3;
  localparam logic [5:0] OP_LCK  = 6'd4;
  localparam logic [5:0] OP_ULK  = 6'd5;
  localparam logic [5:0] OP_EAL  = 6'd6;
  localparam logic [5:0] OP_QPR  = 6'd12;
  localparam logic [5:0] OP_QPRU = 6'd15;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CMD  = 2'd1;
  localparam logic [1:0] A_STS  = 2'd2;
  localparam logic [1:0] A_LOCK = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_PEND, S_EXEC} seq_e;

  function automatic logic op_defined(input logic [5:0] c);
    case (c)
      OP_NOP, OP_WRP, OP_ERP, OP_CPB, OP_LCK, OP_ULK, OP_EAL, OP_QPR, OP_QPRU: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic op_on_array(input logic [5:0] c);
    return (c == OP_WRP) || (c == OP_ERP) || (c == OP_EAL) ||
           (c == OP_QPR) || (c == OP_QPRU);
  endfunction

  function automatic logic op_quick(input logic [5:0] c);
    return (c == OP_QPR) || (c == OP_QPRU);
  endfunction

  function automatic logic op_page_mod(input logic [5:0] c);
    return (c == OP_WRP) || (c == OP_ERP);
  endfunction
endpackage

// File: rtl/fcc_decode.sv
module fcc_decode
  import fcc_pkg::*;
#(
  parameter int PAGE_W     = 16,
  parameter int REGION_W   = 4,
  parameter int BOOT_PAGES = 16
) (
  input  logic [31:0]              word,
  input  logic [(1<<REGION_W)-1:0] lock_map,
  output logic                     key_ok,
  output logic                     op_ok,
  output logic                     lock_hit,
  output logic [5:0]               op,
  output logic [PAGE_W-1:0]        page
);
  localparam logic [PAGE_W-1:0] BOOT_LIM = PAGE_W'(BOOT_PAGES);

  logic [REGION_W-1:0] region;
  logic                boot_hit;
  logic                unused_fields;

  assign unused_fields = ^word[7:6];
  assign op       = word[5:0];
  assign page     = word[8 +: PAGE_W];
  assign key_ok   = (word[31:24] == CMD_KEY);
  assign op_ok    = op_defined(op);
  assign region   = page[PAGE_W-1 -: REGION_W];
  assign boot_hit = (page < BOOT_LIM);

  always_comb begin
    lock_hit = 1'b0;
    if (op_page_mod(op))
      lock_hit = lock_map[region] || boot_hit;
    else if (op == OP_EAL)
      lock_hit = |lock_map;
  end
endmodule

// File: rtl/fcc_seq.sv
module fcc_seq
  import fcc_pkg::*;
#(
  parameter int PAGE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              local_go,
  input  logic [5:0]        op_in,
  input  logic [PAGE_W-1:0] page_in,
  input  logic              mem_rd_req,
  input  logic              fl_done,
  output logic              busy,
  output logic              fl_start,
  output logic [5:0]        fl_op,
  output logic [PAGE_W-1:0] fl_page,
  output logic              mem_rd_ready,
  output logic              cmp,
  output logic [5:0]        cmp_op,
  output logic [PAGE_W-1:0] cmp_page
);
  seq_e              state, state_nx;
  logic [5:0]        op_q;
  logic [PAGE_W-1:0] page_q;
  logic              local_q;

  assign busy         = (state != S_IDLE);
  assign fl_start     = (state == S_PEND) && !local_q && !mem_rd_req;
  assign fl_op        = op_q;
  assign fl_page      = page_q;
  assign mem_rd_ready = (state != S_EXEC);
  assign cmp          = ((state == S_PEND) && local_q) || ((state == S_EXEC) && fl_done);
  assign cmp_op       = op_q;
  assign cmp_page     = page_q;

  always_comb begin
    state_nx = state;
    case (state)
      S_IDLE: if (accept) state_nx = S_PEND;
      S_PEND: if (local_q) state_nx = S_IDLE;
              else if (!mem_rd_req) state_nx = S_EXEC;
      S_EXEC: if (fl_done) state_nx = S_IDLE;
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      op_q    <= '0;
      page_q  <= '0;
      local_q <= 1'b0;
    end else begin
      state <= state_nx;
      if (accept && !busy) begin
        op_q    <= op_in;
        page_q  <= page_in;
        local_q <= local_go;
      end
    end
  end

  // R7
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_start |-> !mem_rd_req);
  // R7
  single_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_start |=> !fl_start);
  // R8
  stall_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_start |=> !mem_rd_ready);
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_rd_ready && !fl_done) |=> !mem_rd_ready);
  // R2
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cmp) |=> busy && $stable(op_q) && $stable(page_q));
endmodule

// File: rtl/fcc_status.sv
module fcc_status
  import fcc_pkg::*;
#(
  parameter int PAGE_W   = 16,
  parameter int REGION_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               addr,
  input  logic                     ctrl_wr,
  input  logic                     ie_in,
  input  logic                     sts_rd,
  input  logic                     accept,
  input  logic                     prog_evt,
  input  logic                     lock_evt,
  input  logic                     cmp,
  input  logic [5:0]               cmp_op,
  input  logic [PAGE_W-1:0]        cmp_page,
  output logic [31:0]              rdata,
  output logic                     irq,
  output logic [(1<<REGION_W)-1:0] lock_map
);
  localparam int NREG = 1 << REGION_W;

  logic                ie, ready, prog_err, lock_err, irq_pend;
  logic [REGION_W-1:0] cmp_region;

  assign cmp_region = cmp_page[PAGE_W-1 -: REGION_W];
  assign irq        = ie && irq_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie       <= 1'b0;
      ready    <= 1'b1;
      prog_err <= 1'b0;
      lock_err <= 1'b0;
      irq_pend <= 1'b0;
      lock_map <= '0;
    end else begin
      if (ctrl_wr) ie <= ie_in;
      if (accept) ready <= 1'b0;
      else if (cmp) ready <= 1'b1;
      if (prog_evt) prog_err <= 1'b1;
      else if (sts_rd) prog_err <= 1'b0;
      if (lock_evt) lock_err <= 1'b1;
      else if (sts_rd) lock_err <= 1'b0;
      if (cmp && !op_quick(cmp_op)) irq_pend <= 1'b1;
      else if (sts_rd || accept) irq_pend <= 1'b0;
      if (cmp && cmp_op == OP_LCK) lock_map[cmp_region] <= 1'b1;
      if (cmp && cmp_op == OP_ULK) lock_map[cmp_region] <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: rdata[0] = ie;
      A_STS:  rdata[2:0] = {lock_err, prog_err, ready};
      A_LOCK: rdata[NREG-1:0] = lock_map;
      default: rdata = '0;
    endcase
  end

  // R4
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_err && !sts_rd) |=> prog_err);
  // R4
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_rd && !prog_evt && !lock_evt) |=> (!prog_err && !lock_err));
  // R5
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ready);
  // R5
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp |=> ready);
  // R6
  quick_noirq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp && op_quick(cmp_op) && !irq_pend) |=> !irq_pend);
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fcc_pkg::*;
#(
  parameter int PAGE_W     = 16,
  parameter int REGION_W   = 4,
  parameter int BOOT_PAGES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  input  logic              mem_rd_req,
  output logic              mem_rd_ready,
  output logic              fl_start,
  output logic [5:0]        fl_op,
  output logic [PAGE_W-1:0] fl_page,
  input  logic              fl_done,
  output logic              pbuf_clear
);
  localparam int NREG = 1 << REGION_W;

  logic              key_ok, op_ok, lock_hit, busy, cmp;
  logic              cmd_wr, accept, prog_evt, lock_evt, sts_rd, ctrl_wr, local_go;
  logic [5:0]        dec_op, cmp_op;
  logic [PAGE_W-1:0] dec_page, cmp_page;
  logic [NREG-1:0]   lock_map;

  assign cmd_wr   = reg_wr && (reg_addr == A_CMD);
  assign ctrl_wr  = reg_wr && (reg_addr == A_CTRL);
  assign sts_rd   = reg_rd && (reg_addr == A_STS);
  assign accept   = cmd_wr && key_ok && op_ok && !busy;
  assign prog_evt = cmd_wr && !(key_ok && op_ok && !busy);
  assign lock_evt = accept && lock_hit;
  assign local_go = lock_hit || !op_on_array(dec_op);
  assign pbuf_clear = cmp && (cmp_op == OP_CPB);

  fcc_decode #(.PAGE_W(PAGE_W), .REGION_W(REGION_W), .BOOT_PAGES(BOOT_PAGES)) u_dec (
    .word(reg_wdata), .lock_map(lock_map), .key_ok(key_ok), .op_ok(op_ok),
    .lock_hit(lock_hit), .op(dec_op), .page(dec_page)
  );

  fcc_seq #(.PAGE_W(PAGE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept), .local_go(local_go),
    .op_in(dec_op), .page_in(dec_page), .mem_rd_req(mem_rd_req), .fl_done(fl_done),
    .busy(busy), .fl_start(fl_start), .fl_op(fl_op), .fl_page(fl_page),
    .mem_rd_ready(mem_rd_ready), .cmp(cmp), .cmp_op(cmp_op), .cmp_page(cmp_page)
  );

  fcc_status #(.PAGE_W(PAGE_W), .REGION_W(REGION_W)) u_sts (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .ctrl_wr(ctrl_wr), .ie_in(reg_wdata[0]),
    .sts_rd(sts_rd), .accept(accept), .prog_evt(prog_evt), .lock_evt(lock_evt),
    .cmp(cmp), .cmp_op(cmp_op), .cmp_page(cmp_page), .rdata(reg_rdata),
    .irq(irq), .lock_map(lock_map)
  );

  // R1
  bad_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_evt && !busy) |=> !fl_start);
  // R3
  lock_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_evt |=> !fl_start);
  // R9
  pbuf_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pbuf_clear |-> !fl_start);
endmodule

// File: tb/flash_cmd_ctrl_bench.sv
module flash_cmd_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, mem_rd_ready, fl_start, pbuf_clear;
  logic        mem_rd_req = 1'b0, fl_done = 1'b0;
  logic [5:0]  fl_op;
  logic [15:0] fl_page;

  int checks = 0, fails = 0;
  bit finished = 0;

  logic [15:0] m_locks = '0;
  bit m_ready = 1, m_prog = 0, m_lerr = 0, m_pend = 0, m_ie = 0;

  always #10 clk = ~clk;

  flash_cmd_ctrl u_flash_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .mem_rd_req(mem_rd_req),
    .mem_rd_ready(mem_rd_ready), .fl_start(fl_start), .fl_op(fl_op), .fl_page(fl_page),
    .fl_done(fl_done), .pbuf_clear(pbuf_clear)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit b_defined(input int c);
    return c inside {0, 1, 2, 3, 4, 5, 6, 12, 15};
  endfunction
  function automatic bit b_array(input int c);
    return c inside {1, 2, 6, 12, 15};
  endfunction
  function automatic bit b_refused(input int c, input logic [15:0] pg, input logic [15:0] lk);
    if (c == 1 || c == 2) return (pg < 16) || lk[pg[15:12]];
    if (c == 6) return lk != 0;
    return 0;
  endfunction
  function automatic logic [31:0] mk(input logic [7:0] key, input logic [15:0] pg, input int c);
    return {key, pg, 2'b00, 6'(c)};
  endfunction

  function automatic logic [31:0] peek(input logic [1:0] a);
    return (a == 2'd2) ? {29'b0, m_lerr, m_prog, m_ready} : 32'h0;
  endfunction

  task automatic status_is(input string req);
    reg_addr = 2'd2; #1;
    chk(reg_rdata[2:0] == peek(2'd2), req, reg_rdata[2:0], peek(2'd2));
    chk(irq == (m_ie && m_pend), {req, " irq"}, irq, m_ie && m_pend);
  endtask

  task automatic read_status();
    @(negedge clk); reg_addr = 2'd2; reg_rd = 1'b1; #1;
    chk(reg_rdata[2:0] == peek(2'd2), "R4 sticky before read", reg_rdata[2:0], peek(2'd2));
    @(negedge clk); reg_rd = 1'b0;
    m_prog = 0; m_lerr = 0; m_pend = 0;
    status_is("R4 cleared by status read");
  endtask

  task automatic set_ie(input bit v);
    @(negedge clk); reg_addr = 2'd0; reg_wdata = {31'b0, v}; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0; m_ie = v; #1;
    chk(reg_rdata[0] == v, "R6 enable bit", reg_rdata[0], v);
  endtask

  task automatic run_cmd(input logic [31:0] w, input int delay, input int burst);
    int c = int'(w[5:0]);
    logic [15:0] pg = w[23:8];
    bit bad = (w[31:24] != 8'hA5) || !b_defined(c);
    bit refused = !bad && b_refused(c, pg, m_locks);
    bit arr = !bad && !refused && b_array(c);
    @(negedge clk);
    reg_addr = 2'd1; reg_wdata = w; reg_wr = 1'b1; mem_rd_req = (burst > 0);
    @(negedge clk); reg_wr = 1'b0;
    if (bad) begin
      m_prog = 1;
      status_is("R1 bad word");
      chk(fl_start == 0, "R1 no start", fl_start, 0);
      mem_rd_req = 0;
      return;
    end
    m_ready = 0; m_pend = 0;
    if (refused) m_lerr = 1;
    status_is(refused ? "R3 refused" : "R5 ready low");
    if (!arr) begin
      chk(fl_start == 0, refused ? "R3 no start" : "R7 local no start", fl_start, 0);
      chk(pbuf_clear == (c == 3), "R9 clear pulse", pbuf_clear, c == 3);
      @(negedge clk); mem_rd_req = 0;
      if (c == 4 && !refused) m_locks[pg[15:12]] = 1'b1;
      if (c == 5 && !refused) m_locks[pg[15:12]] = 1'b0;
      m_ready = 1; m_pend = 1;
      status_is("R7 local completion");
      reg_addr = 2'd3; #1;
      chk(reg_rdata[15:0] == m_locks, "R10 lock map", reg_rdata[15:0], m_locks);
      return;
    end
    for (int i = 0; i < burst; i++) begin
      #1 chk(fl_start == 0, "R7 start held by burst", fl_start, 0);
      @(negedge clk);
    end
    mem_rd_req = 0; #1;
    chk(fl_start == 1, "R7 start on idle", fl_start, 1);
    chk(fl_op == 6'(c) && fl_page == pg, "R7 op/page", {fl_op, fl_page}, {6'(c), pg});
    chk(pbuf_clear == 0, "R9 no clear on array op", pbuf_clear, 0);
    @(negedge clk); mem_rd_req = 1; #1;
    chk(mem_rd_ready == 0, "R8 read stalled", mem_rd_ready, 0);
    for (int i = 1; i < delay; i++) @(negedge clk);
    fl_done = 1;
    @(negedge clk); fl_done = 0; #1;
    chk(mem_rd_ready == 1, "R8 read released", mem_rd_ready, 1);
    mem_rd_req = 0;
    m_ready = 1;
    if (!(c == 12 || c == 15)) m_pend = 1;
    status_is("R6 completion");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    status_is("R5 reset state");
    chk(mem_rd_ready == 1 && fl_start == 0, "R8 reset idle", {mem_rd_ready, fl_start}, 2'b10);
    set_ie(1);
    // Directed corners
    run_cmd(mk(8'h5A, 16'h2000, 1), 3, 0);          // R1 wrong key
    run_cmd(mk(8'hA5, 16'h2000, 9), 3, 0);          // R1 undefined opcode
    read_status();
    run_cmd(mk(8'hA5, 16'h2010, 1), 4, 3);          // R7 burst delays start
    run_cmd(mk(8'hA5, 16'h0005, 2), 2, 0);          // R3 boot page
    run_cmd(mk(8'hA5, 16'h3000, 4), 1, 0);          // R10 lock region 3
    run_cmd(mk(8'hA5, 16'h3044, 1), 2, 0);          // R3 locked region
    run_cmd(mk(8'hA5, 16'h0000, 6), 2, 0);          // R3 erase all refused
    run_cmd(mk(8'hA5, 16'h3000, 5), 1, 0);          // R10 unlock
    read_status();
    run_cmd(mk(8'hA5, 16'h4000, 12), 3, 1);         // R6 quick read no irq
    run_cmd(mk(8'hA5, 16'h4000, 15), 2, 0);         // R6 quick user read
    run_cmd(mk(8'hA5, 16'h0000, 3), 1, 0);          // R9 page buffer clear
    run_cmd(mk(8'hA5, 16'h0000, 6), 2, 0);          // erase all allowed
    // R2: write while executing
    @(negedge clk); reg_addr = 2'd1; reg_wdata = mk(8'hA5, 16'h5000, 2); reg_wr = 1;
    @(negedge clk); reg_wr = 0; m_ready = 0; m_pend = 0; #1;
    chk(fl_start == 1, "R2 first start", fl_start, 1);
    @(negedge clk); reg_wdata = mk(8'hA5, 16'h6000, 1); reg_wr = 1;
    @(negedge clk); reg_wr = 0; m_prog = 1; #1;
    chk(fl_start == 0, "R2 no second start", fl_start, 0);
    status_is("R2 busy write flagged");
    fl_done = 1; @(negedge clk); fl_done = 0; m_ready = 1; m_pend = 1;
    status_is("R2 original completes");
    read_status();
    // Constrained random
    for (int n = 0; n < 300; n++) begin
      int ops[12] = '{0, 1, 2, 3, 4, 5, 6, 12, 15, 7, 9, 40};
      int c = ops[$urandom_range(0, 11)];
      logic [7:0] key = ($urandom_range(0, 9) == 0) ? 8'($urandom) : 8'hA5;
      logic [15:0] pg = ($urandom_range(0, 7) == 0) ? 16'($urandom_range(0, 15)) : 16'($urandom);
      if (n % 25 == 0) set_ie(1'($urandom));
      run_cmd(mk(key, pg, c), $urandom_range(1, 8), $urandom_range(0, 3));
      if ($urandom_range(0, 4) == 0) read_status();
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule